// File: doc/BRIEF.md
# Byte and Pair Register File with Branch Condition Decode

This block stores the general-purpose state of a small accumulator-oriented processor: eight byte-wide registers and a separate 16-bit stack pointer. The execution datapath addresses the byte registers with a 3-bit operand code and addresses the 16-bit register pairs with a 2-bit pair code. One byte operand code does not name a register. It names the byte in memory whose address is held in the H/L pair. For that code the block issues a memory read or write request carrying that address and leaves its own storage alone.

A 2-bit condition code is evaluated against the flag register, which is the eighth byte register. The result drives branch decisions. All reads are combinational. Each clock accepts one byte write, one pair write and one flag write, and a pair write overrides a byte write that targets the same register. Reset is asserted asynchronously and released in step with the clock through a two-stage synchronizer. Writes therefore take effect from the third rising edge after `rst_n` goes high.

Top module: `cpu_regfile`

## Requirements
- R1: On the byte read port, codes 0 to 5 return B, C, D, E, H and L, code 7 returns A, and code 6 returns 8'h00.
- R2: A byte write with codes 0 to 5 or 7 updates the selected register at the next rising edge. A byte write with code 6 leaves every register and the stack pointer unchanged.
- R3: `mem_rd_req` is high exactly when a byte read is enabled with code 6. `mem_wr_req` is high exactly when a byte write is enabled with code 6. `mem_addr` always shows {H,L}, and `mem_wr_data` carries the byte write data.
- R4: On the pair read port, code 0 returns {B,C}, code 1 returns {D,E}, code 2 returns {H,L} and code 3 returns the stack pointer, with the first-named register in bits 15:8.
- R5: A pair write with codes 0 to 2 places bits 15:8 in the first-named register and bits 7:0 in the second. Code 3 loads the stack pointer.
- R6: When a pair write and a byte write target the same register in one cycle, the register takes the pair write's byte.
- R7: The flag register (`flags`) holds zero in bit 7, subtract in bit 6, half-carry in bit 5 and carry in bit 4. It is loaded through the flag write port, and its bits 3:0 always read as zero.
- R8: `cond_true` for condition code 0 is "flag bit 7 clear", for code 1 is "bit 7 set", for code 2 is "bit 4 clear" and for code 3 is "bit 4 set".
- R9: After reset, all eight byte registers read zero and the stack pointer reads `SP_RESET` (default 16'hFFFE).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_rd_en | input | 1 | Byte read in use (raises memory read for code 6) |
| byte_rd_code | input | 3 | Byte read operand code |
| byte_rd_data | output | 8 | Byte read result |
| byte_wr_en | input | 1 | Byte write enable |
| byte_wr_code | input | 3 | Byte write operand code |
| byte_wr_data | input | 8 | Byte write data |
| pair_rd_code | input | 2 | Pair read code |
| pair_rd_data | output | 16 | Pair read result |
| pair_wr_en | input | 1 | Pair write enable |
| pair_wr_code | input | 2 | Pair write code |
| pair_wr_data | input | 16 | Pair write data |
| flag_wr_en | input | 1 | Flag register write enable |
| flag_wr_data | input | 8 | Flag register write data |
| flags | output | 8 | Current flag register |
| cond_code | input | 2 | Branch condition code |
| cond_true | output | 1 | Condition result |
| mem_rd_req | output | 1 | Memory read request for the H/L operand |
| mem_wr_req | output | 1 | Memory write request for the H/L operand |
| mem_addr | output | 16 | Memory address, always {H,L} |
| mem_wr_data | output | 8 | Memory write data |

## Verification
The read ports are tried with every code after writes with distinct values to each register. This separates a swapped byte or pair mapping from a correct one, and separates the accumulator code from the memory code. Every pair is written with unequal high and low bytes, which shows whether the halves are ordered correctly. Same-cycle pair and byte writes to one register show whether the write priority is honoured. All sixteen upper-nibble flag patterns, each combined with a nonzero low nibble, are applied against all four condition codes, which shows both the bit positions tested and the low-nibble masking. A long run of random mixed traffic, including code 6 and overlapping writes, is compared every cycle with the behavioural model.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int NREGS = 8;
  localparam int IDX_A = 6;
  localparam int IDX_F = 7;
  localparam logic [2:0] BCODE_MEM = 3'd6;
  localparam logic [2:0] BCODE_ACC = 3'd7;
  localparam logic [1:0] PCODE_SP  = 2'd3;
  localparam int FBIT_ZERO  = 7;
  localparam int FBIT_CARRY = 4;
  localparam logic [7:0] FLAG_MASK = 8'hF0;

  typedef enum logic [1:0] {
    COND_NZ = 2'd0,
    COND_Z  = 2'd1,
    COND_NC = 2'd2,
    COND_C  = 2'd3
  } cond_e;
endpackage

// File: rtl/crf_rst_sync.sv
module crf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/crf_byte_dec.sv
module crf_byte_dec
  import crf_pkg::*;
(
  input  logic             en,
  input  logic [2:0]       code,
  output logic [NREGS-1:0] sel,
  output logic             mem_hit
);
  logic [2:0] idx;

  always_comb begin
    idx     = (code == BCODE_ACC) ? 3'(IDX_A) : code;
    mem_hit = en && (code == BCODE_MEM);
    for (int i = 0; i < NREGS; i++) begin
      sel[i] = en && (code != BCODE_MEM) && (idx == 3'(i));
    end
  end
endmodule

// File: rtl/crf_pair_dec.sv
module crf_pair_dec
  import crf_pkg::*;
(
  input  logic             en,
  input  logic [1:0]       code,
  output logic [NREGS-1:0] hi_sel,
  output logic [NREGS-1:0] lo_sel,
  output logic             sp_sel
);
  always_comb begin
    sp_sel = en && (code == PCODE_SP);
    for (int i = 0; i < NREGS; i++) begin
      hi_sel[i] = en && (code != PCODE_SP) && ({code, 1'b0} == 3'(i));
      lo_sel[i] = en && (code != PCODE_SP) && ({code, 1'b1} == 3'(i));
    end
  end
endmodule

// File: rtl/crf_cond_eval.sv
module crf_cond_eval
  import crf_pkg::*;
(
  input  logic [7:0] flag_byte,
  input  logic [1:0] code,
  output logic       taken
);
  always_comb begin
    unique case (cond_e'(code))
      COND_NZ: taken = !flag_byte[FBIT_ZERO];
      COND_Z:  taken =  flag_byte[FBIT_ZERO];
      COND_NC: taken = !flag_byte[FBIT_CARRY];
      COND_C:  taken =  flag_byte[FBIT_CARRY];
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import crf_pkg::*;
#(
  parameter int          DW       = 8,
  parameter logic [15:0] SP_RESET = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_rd_en,
  input  logic [2:0]    byte_rd_code,
  output logic [DW-1:0] byte_rd_data,
  input  logic          byte_wr_en,
  input  logic [2:0]    byte_wr_code,
  input  logic [DW-1:0] byte_wr_data,
  input  logic [1:0]    pair_rd_code,
  output logic [2*DW-1:0] pair_rd_data,
  input  logic          pair_wr_en,
  input  logic [1:0]    pair_wr_code,
  input  logic [2*DW-1:0] pair_wr_data,
  input  logic          flag_wr_en,
  input  logic [DW-1:0] flag_wr_data,
  output logic [DW-1:0] flags,
  input  logic [1:0]    cond_code,
  output logic          cond_true,
  output logic          mem_rd_req,
  output logic          mem_wr_req,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wr_data
);
  localparam int PW = 2 * DW;

  logic rst_sync_n;
  logic [DW-1:0] regs_q [NREGS];
  logic [DW-1:0] regs_d [NREGS];
  logic [NREGS-1:0] reg_we;
  logic [PW-1:0] sp_q, sp_d;
  logic sp_we;
  logic [NREGS-1:0] bw_sel, ph_sel, pl_sel;
  logic bw_mem, pw_sp;
  logic [NREGS-1:0] br_sel_unused;
  logic br_mem;
  logic [NREGS*DW-1:0] regs_flat;

  crf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  crf_byte_dec u_bw_dec (
    .en(byte_wr_en), .code(byte_wr_code), .sel(bw_sel), .mem_hit(bw_mem)
  );

  crf_byte_dec u_br_dec (
    .en(byte_rd_en), .code(byte_rd_code), .sel(br_sel_unused), .mem_hit(br_mem)
  );

  crf_pair_dec u_pw_dec (
    .en(pair_wr_en), .code(pair_wr_code),
    .hi_sel(ph_sel), .lo_sel(pl_sel), .sp_sel(pw_sp)
  );

  // Next-state and register processes, one per byte register
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == IDX_F) begin : g_flag
      always_comb begin
        regs_d[g] = regs_q[g];
        reg_we[g] = flag_wr_en;
        if (flag_wr_en) regs_d[g] = flag_wr_data & DW'(FLAG_MASK);
      end
    end else begin : g_gp
      always_comb begin
        regs_d[g] = regs_q[g];
        reg_we[g] = bw_sel[g] | ph_sel[g] | pl_sel[g];
        if (bw_sel[g]) regs_d[g] = byte_wr_data;
        // pair write overrides a byte write to the same register
        if (ph_sel[g]) regs_d[g] = pair_wr_data[PW-1:DW];
        if (pl_sel[g]) regs_d[g] = pair_wr_data[DW-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)    regs_q[g] <= '0;
      else if (reg_we[g]) regs_q[g] <= regs_d[g];
    end

    assign regs_flat[g*DW +: DW] = regs_q[g];
  end

  always_comb begin
    sp_we = pw_sp;
    sp_d  = pair_wr_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sp_q <= SP_RESET;
    else if (sp_we)  sp_q <= sp_d;
  end

  // Combinational read paths
  always_comb begin
    if (byte_rd_code == BCODE_MEM)      byte_rd_data = '0;
    else if (byte_rd_code == BCODE_ACC) byte_rd_data = regs_q[IDX_A];
    else                                byte_rd_data = regs_q[byte_rd_code];
  end

  always_comb begin
    if (pair_rd_code == PCODE_SP) pair_rd_data = sp_q;
    else pair_rd_data = {regs_q[{pair_rd_code, 1'b0}], regs_q[{pair_rd_code, 1'b1}]};
  end

  assign flags       = regs_q[IDX_F];
  assign mem_rd_req  = br_mem;
  assign mem_wr_req  = bw_mem;
  assign mem_addr    = {regs_q[4], regs_q[5]};
  assign mem_wr_data = byte_wr_data;

  crf_cond_eval u_cond (
    .flag_byte(regs_q[IDX_F][7:0]), .code(cond_code), .taken(cond_true)
  );
endmodule

// File: rtl/crf_checker.sv
module crf_checker #(
  parameter int          DW       = 8,
  parameter logic [15:0] SP_RESET = 16'hFFFE
) (
  input logic            clk,
  input logic            rst_n_int,
  input logic            byte_wr_en,
  input logic [2:0]      byte_wr_code,
  input logic            pair_wr_en,
  input logic [1:0]      pair_wr_code,
  input logic [2*DW-1:0] pair_wr_data,
  input logic            flag_wr_en,
  input logic [DW-1:0]   flags,
  input logic [1:0]      cond_code,
  input logic            cond_true,
  input logic [2*DW-1:0] mem_addr,
  input logic [2*DW-1:0] sp_q,
  input logic [8*DW-1:0] regs_flat
);
  assert_mem_write_keeps_regs_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (byte_wr_en && byte_wr_code == 3'd6 && !pair_wr_en && !flag_wr_en)
      |=> ($stable(regs_flat) && $stable(sp_q)));

  assert_hl_feeds_addr_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (pair_wr_en && pair_wr_code == 2'd2) |=> (mem_addr == $past(pair_wr_data)));

  assert_pair_beats_byte_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (pair_wr_en && pair_wr_code == 2'd0 && byte_wr_en && byte_wr_code == 3'd0)
      |=> (regs_flat[DW-1:0] == $past(pair_wr_data[2*DW-1:DW])));

  assert_flag_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    flags[3:0] == 4'h0);

  assert_cond_zero_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cond_code == 2'd1) |-> (cond_true == flags[7]));

  assert_cond_carry_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cond_code == 2'd2) |-> (cond_true == !flags[4]));

  assert_reset_values_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(rst_n_int) |-> (regs_flat == '0 && sp_q == SP_RESET));
endmodule

bind cpu_regfile crf_checker #(.DW(DW), .SP_RESET(SP_RESET)) u_crf_checker (
  .clk(clk), .rst_n_int(rst_sync_n),
  .byte_wr_en(byte_wr_en), .byte_wr_code(byte_wr_code),
  .pair_wr_en(pair_wr_en), .pair_wr_code(pair_wr_code), .pair_wr_data(pair_wr_data),
  .flag_wr_en(flag_wr_en), .flags(flags),
  .cond_code(cond_code), .cond_true(cond_true),
  .mem_addr(mem_addr), .sp_q(sp_q), .regs_flat(regs_flat)
);

// File: tb/test_cpu_regfile.sv
`timescale 1ns/1ps
module test_cpu_regfile;
  logic clk = 1'b0;
  logic rst_n;
  logic byte_rd_en, byte_wr_en, pair_wr_en, flag_wr_en;
  logic [2:0] byte_rd_code, byte_wr_code;
  logic [7:0] byte_rd_data, byte_wr_data, flag_wr_data, flags, mem_wr_data;
  logic [1:0] pair_rd_code, pair_wr_code, cond_code;
  logic [15:0] pair_rd_data, pair_wr_data, mem_addr;
  logic cond_true, mem_rd_req, mem_wr_req;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0]  m [8];
  logic [15:0] msp;

  always #5 clk = ~clk;

  cpu_regfile i_cpu_regfile (
    .clk(clk), .rst_n(rst_n),
    .byte_rd_en(byte_rd_en), .byte_rd_code(byte_rd_code), .byte_rd_data(byte_rd_data),
    .byte_wr_en(byte_wr_en), .byte_wr_code(byte_wr_code), .byte_wr_data(byte_wr_data),
    .pair_rd_code(pair_rd_code), .pair_rd_data(pair_rd_data),
    .pair_wr_en(pair_wr_en), .pair_wr_code(pair_wr_code), .pair_wr_data(pair_wr_data),
    .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data), .flags(flags),
    .cond_code(cond_code), .cond_true(cond_true),
    .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
    .mem_addr(mem_addr), .mem_wr_data(mem_wr_data)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [2:0] c);
    if (c == 3'd6) return 8'h00;
    if (c == 3'd7) return m[6];
    return m[c];
  endfunction

  function automatic logic [15:0] exp_pair(input logic [1:0] c);
    if (c == 2'd3) return msp;
    return {m[2*c], m[2*c+1]};
  endfunction

  function automatic logic exp_cond(input logic [1:0] c);
    case (c)
      2'd0: return m[7][7] == 1'b0;
      2'd1: return m[7][7] == 1'b1;
      2'd2: return m[7][4] == 1'b0;
      default: return m[7][4] == 1'b1;
    endcase
  endfunction

  task automatic compare_all();
    chk(byte_rd_data == exp_byte(byte_rd_code), "R1 byte read", {8'h0, byte_rd_data}, {8'h0, exp_byte(byte_rd_code)});
    chk(pair_rd_data == exp_pair(pair_rd_code), "R4 pair read", pair_rd_data, exp_pair(pair_rd_code));
    chk(flags == m[7], "R7 flags", {8'h0, flags}, {8'h0, m[7]});
    chk(cond_true == exp_cond(cond_code), "R8 cond", {15'h0, cond_true}, {15'h0, exp_cond(cond_code)});
    chk(mem_rd_req == (byte_rd_en && byte_rd_code == 3'd6), "R3 mem_rd_req",
        {15'h0, mem_rd_req}, {15'h0, (byte_rd_en && byte_rd_code == 3'd6)});
    chk(mem_wr_req == (byte_wr_en && byte_wr_code == 3'd6), "R3 mem_wr_req",
        {15'h0, mem_wr_req}, {15'h0, (byte_wr_en && byte_wr_code == 3'd6)});
    chk(mem_addr == {m[4], m[5]}, "R3 mem_addr", mem_addr, {m[4], m[5]});
    chk(mem_wr_data == byte_wr_data, "R3 mem_wr_data", {8'h0, mem_wr_data}, {8'h0, byte_wr_data});
  endtask

  task automatic model_update();
    if (byte_wr_en && byte_wr_code != 3'd6)
      m[(byte_wr_code == 3'd7) ? 6 : int'(byte_wr_code)] = byte_wr_data;
    if (flag_wr_en) m[7] = flag_wr_data & 8'hF0;
    if (pair_wr_en) begin
      if (pair_wr_code == 2'd3) msp = pair_wr_data;
      else begin
        m[2*pair_wr_code]   = pair_wr_data[15:8];
        m[2*pair_wr_code+1] = pair_wr_data[7:0];
      end
    end
  endtask

  task automatic cyc();
    #1;
    compare_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    byte_wr_en = 0; pair_wr_en = 0; flag_wr_en = 0; byte_rd_en = 0;
  endtask

  task automatic sweep_reads(input string req);
    for (int c = 0; c < 8; c++) begin
      byte_rd_code = 3'(c);
      #1;
      chk(byte_rd_data == exp_byte(3'(c)), req, {8'h0, byte_rd_data}, {8'h0, exp_byte(3'(c))});
    end
    for (int p = 0; p < 4; p++) begin
      pair_rd_code = 2'(p);
      #1;
      chk(pair_rd_data == exp_pair(2'(p)), req, pair_rd_data, exp_pair(2'(p)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle();
    byte_rd_code = 0; byte_wr_code = 0; byte_wr_data = 0;
    pair_rd_code = 0; pair_wr_code = 0; pair_wr_data = 0;
    flag_wr_data = 0; cond_code = 0;
    for (int i = 0; i < 8; i++) m[i] = 8'h00;
    msp = 16'hFFFE;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R9: reset state through all read codes
    sweep_reads("R9 reset value");

    // R2: write distinct values through every register byte code
    for (int c = 0; c < 8; c++) begin
      if (c == 6) continue;
      byte_wr_en = 1; byte_wr_code = 3'(c); byte_wr_data = 8'h11 * 8'(c + 1);
      cyc();
    end
    idle();
    sweep_reads("R2 byte write readback");
    sweep_reads("R1 byte map");

    // R2/R3: code 6 write leaves storage alone and raises a request
    byte_wr_en = 1; byte_wr_code = 3'd6; byte_wr_data = 8'hA5;
    byte_rd_en = 1; byte_rd_code = 3'd6;
    cyc();
    idle();
    sweep_reads("R2 code6 no change");

    // R5: pair writes with unequal halves, including SP
    for (int p = 0; p < 4; p++) begin
      pair_wr_en = 1; pair_wr_code = 2'(p); pair_wr_data = 16'h1234 + 16'(p) * 16'h2222;
      cyc();
    end
    idle();
    sweep_reads("R5 pair write readback");

    // R6: pair and byte write on the same register, both halves
    pair_wr_en = 1; pair_wr_code = 2'd0; pair_wr_data = 16'hBEEF;
    byte_wr_en = 1; byte_wr_code = 3'd0; byte_wr_data = 8'h55;
    cyc();
    byte_wr_code = 3'd1; pair_wr_data = 16'hCAFE;
    cyc();
    idle();
    pair_rd_code = 2'd0; #1;
    chk(pair_rd_data == 16'hCAFE, "R6 pair priority", pair_rd_data, 16'hCAFE);

    // R7/R8: all flag patterns with a dirty low nibble, every condition
    for (int f = 0; f < 16; f++) begin
      flag_wr_en = 1; flag_wr_data = {4'(f), 4'hF};
      cyc();
      flag_wr_en = 0;
      for (int c = 0; c < 4; c++) begin
        cond_code = 2'(c);
        cyc();
      end
    end

    // Random mixed traffic
    for (int n = 0; n < 3000; n++) begin
      byte_rd_en   = 1'($urandom);
      byte_rd_code = 3'($urandom);
      byte_wr_en   = 1'($urandom);
      byte_wr_code = 3'($urandom);
      byte_wr_data = 8'($urandom);
      pair_rd_code = 2'($urandom);
      pair_wr_en   = ($urandom % 3) == 0;
      pair_wr_code = 2'($urandom);
      pair_wr_data = 16'($urandom);
      flag_wr_en   = ($urandom % 4) == 0;
      flag_wr_data = 8'($urandom);
      cond_code    = 2'($urandom);
      cyc();
    end
    idle();
    sweep_reads("R1 final");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule